// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests and hands exactly one of them to a processor core. It presents the request as a vector number and a vector address. Requests come from three places. Internal peripheral sources raise level requests. External pins are synchronized and decoded as a low level, a falling edge or a rising edge. A reset request cannot be masked. The controller owns a global enable bit. The core sets or clears this bit with single-cycle strobes. Accepting an interrupt clears the bit, and a return-from-interrupt strobe sets it again.

Vector 1 is the reset request. Vectors 2 up to `NUM_EXT+1` are the external lines, in line order. The internal sources follow them. A smaller vector number always wins. The vector address is the table base plus four bytes for each vector slot. Software can move the table base through a small register write port. The same port holds the per-line enables and trigger modes of the external lines. The core takes the presented request by pulsing `irq_ack` while `irq_valid` is high.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A reset request cannot be masked and is vector 1. A reset request is raised by `rst` and by a pulse on `rst_req`. It is presented even when `gie` is 0. Acknowledging vector 1 drops it.
- R2: When several requests are eligible, the smallest vector number is presented.
- R3: `irq_addr` equals the table base plus 4 × (`irq_vec` − 1). The table base is 0 after reset.
- R4: A write with `cfg_sel`=2 loads the table base from `cfg_wdata`. Later vector addresses are offset by that base.
- R5: `gie` is 0 after reset. An `irq_ack` clears it. A `reti` strobe sets it.
- R6: `gie_set` sets `gie` and `gie_clr` clears it. When `irq_ack` comes in the same cycle as either strobe, the acknowledge wins and `gie` ends up 0.
- R7: Internal source j has no individual mask. It is vector `NUM_EXT`+2+j and is eligible whenever its request is high and `gie` is 1.
- R8: External line i is vector 2+i. It is eligible only when `gie` is 1 and its enable bit i is 1. A write with `cfg_sel`=0 loads the enable bits from `cfg_wdata` bit i.
- R9: A write with `cfg_sel`=1 loads the trigger mode of line i from `cfg_wdata[2i+1:2i]`. The codes are 00 low level, 01 off, 10 falling edge and 11 rising edge. All lines start in the off mode. A low-level request follows the pin and is not remembered.
- R10: An edge-mode line remembers a detected edge, even while it is masked. The remembered edge is forgotten when that line's vector is acknowledged.
- R11: If `gie` is set again inside a handler, any eligible request is taken, including a lower-priority one. This allows nesting.
- R12: The cycle after an `irq_ack`, `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also raises the reset request |
| int_req | input | NUM_INT | Internal source level requests |
| ext_pin | input | NUM_EXT | Asynchronous external request pins |
| rst_req | input | 1 | Pulse that raises the unmaskable reset request |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 enables, 1 trigger modes, 2 table base |
| cfg_wdata | input | ADDR_W | Register write data |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| irq_ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | VEC_W | Presented vector number (1 = reset) |
| irq_addr | output | ADDR_W | Presented vector address |
| gie | output | 1 | Global enable state |

## Verification
Internal requests are raised one at a time and then stacked. This shows whether the global bit alone gates them and whether the smallest vector wins over the larger ones already pending. External lines are driven with a sustained low, with short low pulses, and with low-then-high transitions in each trigger mode. These patterns separate the followed level from the remembered edge, and a wrong edge polarity from the right one. Accept, return, set and clear strobes are mixed, including an acknowledge together with a set. Requests are raised inside a handler before and after re-enabling, and these cases expose nesting and the precedence of the strobes. A relocated table base and a reset request while masked show the address arithmetic and the unmaskable path.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_OFF  = 2'b01,
    TRG_FALL = 2'b10,
    TRG_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/vic_ext_line.sv
module vic_ext_line
  import vic_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin,
  input  trig_e mode,
  input  logic  clr_pend,
  output logic  req
);
  // two-flop synchronizer plus one history flop for edge detection
  logic s1, s2, s3;
  logic rise, fall, pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else begin
      case (mode)
        TRG_FALL: if (fall) pend <= 1'b1; else if (clr_pend) pend <= 1'b0;
        TRG_RISE: if (rise) pend <= 1'b1; else if (clr_pend) pend <= 1'b0;
        default:  pend <= 1'b0;
      endcase
    end
  end

  always_comb begin
    case (mode)
      TRG_LOW:  req = ~s2;
      TRG_FALL: req = pend;
      TRG_RISE: req = pend;
      default:  req = 1'b0;
    endcase
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NV    = 7,
  parameter int VEC_W = 3
) (
  input  logic [NV-1:0]    req,
  output logic             any,
  output logic [VEC_W-1:0] idx
);
  // lowest index has highest priority
  always_comb begin
    any = |req;
    idx = '0;
    for (int k = NV - 1; k >= 0; k--) begin
      if (req[k]) idx = VEC_W'(k);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 2,
  parameter int ADDR_W  = 16,
  localparam int NV     = 1 + NUM_EXT + NUM_INT,
  localparam int VEC_W  = $clog2(NV + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_INT-1:0] int_req,
  input  logic [NUM_EXT-1:0] ext_pin,
  input  logic               rst_req,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               irq_ack,
  input  logic               reti,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [ADDR_W-1:0]  irq_addr,
  output logic               gie
);
  localparam int EXT_BASE = 1;
  localparam int INT_BASE = 1 + NUM_EXT;

  logic [NUM_EXT-1:0] ext_en_q;
  trig_e              mode_q [NUM_EXT];
  logic [ADDR_W-1:0]  base_q;
  logic               rst_pend;
  logic [NUM_EXT-1:0] ext_raw;
  logic [NV-1:0]      elig;
  logic               win_any;
  logic [VEC_W-1:0]   win_idx;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_en_q <= '0;
      base_q   <= '0;
      for (int i = 0; i < NUM_EXT; i++) mode_q[i] <= TRG_OFF;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: ext_en_q <= cfg_wdata[NUM_EXT-1:0];
        2'd1: for (int i = 0; i < NUM_EXT; i++) mode_q[i] <= trig_e'(cfg_wdata[2*i +: 2]);
        2'd2: base_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // global enable: acknowledge dominates, then return, then clear, then set
  always_ff @(posedge clk) begin
    if (rst)          gie <= 1'b0;
    else if (irq_ack) gie <= 1'b0;
    else if (reti)    gie <= 1'b1;
    else if (gie_clr) gie <= 1'b0;
    else if (gie_set) gie <= 1'b1;
  end

  // unmaskable reset request, vector 1
  always_ff @(posedge clk) begin
    if (rst)                                      rst_pend <= 1'b1;
    else if (rst_req)                             rst_pend <= 1'b1;
    else if (irq_ack && irq_vec == VEC_W'(1))     rst_pend <= 1'b0;
  end

  generate
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
      logic clr_i;
      assign clr_i = irq_ack && (irq_vec == VEC_W'(EXT_BASE + 1 + i));
      vic_ext_line u_line (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin[i]),
        .mode     (mode_q[i]),
        .clr_pend (clr_i),
        .req      (ext_raw[i])
      );
      assign elig[EXT_BASE + i] = ext_raw[i] & ext_en_q[i] & gie;
    end
    for (genvar j = 0; j < NUM_INT; j++) begin : g_int
      assign elig[INT_BASE + j] = int_req[j] & gie;
    end
  endgenerate

  assign elig[0] = rst_pend;

  vic_arbiter #(.NV(NV), .VEC_W(VEC_W)) u_arb (
    .req (elig),
    .any (win_any),
    .idx (win_idx)
  );

  // registered outputs, held off for the cycle after an acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_addr  <= '0;
    end else begin
      irq_valid <= win_any && !irq_ack;
      irq_vec   <= win_idx + VEC_W'(1);
      irq_addr  <= base_q + (ADDR_W'(win_idx) << 2);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 2,
  parameter int ADDR_W  = 16,
  localparam int NV     = 1 + NUM_EXT + NUM_INT,
  localparam int VEC_W  = $clog2(NV + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              gie,
  input logic              irq_ack,
  input logic              reti,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vec,
  input logic [ADDR_W-1:0] irq_addr,
  input logic [ADDR_W-1:0] base_q
);
  // R5
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !gie);

  // R5
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !irq_ack) |=> gie);

  // R12
  ack_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_valid);

  // R7 R8
  masked_only_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_vec != VEC_W'(1)) |-> $past(gie));

  // R3
  addr_map_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && $stable(base_q)) |->
      irq_addr == base_q + ((ADDR_W'(irq_vec) - ADDR_W'(1)) << 2));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .NUM_INT (NUM_INT),
  .NUM_EXT (NUM_EXT),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gie       (gie),
  .irq_ack   (irq_ack),
  .reti      (reti),
  .irq_valid (irq_valid),
  .irq_vec   (irq_vec),
  .irq_addr  (irq_addr),
  .base_q    (base_q)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int NUM_INT = 4;
  localparam int NUM_EXT = 2;
  localparam int ADDR_W  = 16;
  localparam int VEC_W   = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_INT-1:0] int_req = '0;
  logic [NUM_EXT-1:0] ext_pin = '1;
  logic               rst_req = 1'b0;
  logic               cfg_we = 1'b0;
  logic [1:0]         cfg_sel = '0;
  logic [ADDR_W-1:0]  cfg_wdata = '0;
  logic               gie_set = 1'b0, gie_clr = 1'b0, irq_ack = 1'b0, reti = 1'b0;
  logic               irq_valid, gie;
  logic [VEC_W-1:0]   irq_vec;
  logic [ADDR_W-1:0]  irq_addr;

  int n_chk = 0, n_fail = 0;
  int base_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .int_req(int_req), .ext_pin(ext_pin), .rst_req(rst_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .gie_set(gie_set), .gie_clr(gie_clr), .irq_ack(irq_ack), .reti(reti),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_addr(irq_addr), .gie(gie)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_irq(string tag, bit v, int vec);
    chk({tag, " valid"}, int'(irq_valid), int'(v));
    if (v) begin
      chk({tag, " vec"}, int'(irq_vec), vec);
      chk({tag, " addr"}, int'(irq_addr), (base_m + 4 * (vec - 1)) & 16'hFFFF);
    end
  endtask

  task automatic do_ack;   irq_ack = 1; step(1); irq_ack = 0; endtask
  task automatic do_reti;  reti = 1;    step(1); reti = 0;    endtask
  task automatic do_set;   gie_set = 1; step(1); gie_set = 0; endtask
  task automatic do_clr;   gie_clr = 1; step(1); gie_clr = 0; endtask
  task automatic wcfg(int sel, int data);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = ADDR_W'(data);
    step(1);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    step(3); rst = 0; step(2);
    check_irq("R1 R3 reset vector after reset", 1, 1);
    chk("R5 gie low after reset", int'(gie), 0);
    do_ack;
    check_irq("R12 valid drops after ack", 0, 0);
    step(2);
    check_irq("R1 reset request cleared by ack", 0, 0);
  endtask

  task automatic t_internal;
    int_req[1] = 1; step(3);
    check_irq("R7 internal blocked while gie low", 0, 0);
    do_set; step(1);
    chk("R6 gie_set", int'(gie), 1);
    check_irq("R7 internal source 1", 1, 5);
    int_req[3] = 1; step(2);
    check_irq("R2 source 1 beats source 3", 1, 5);
    int_req[0] = 1; step(2);
    check_irq("R2 source 0 beats source 1", 1, 4);
    do_ack;
    chk("R5 ack clears gie", int'(gie), 0);
    check_irq("R12 no output after ack", 0, 0);
    step(2);
    check_irq("R5 masked after ack", 0, 0);
    do_reti; step(1);
    chk("R5 reti sets gie", int'(gie), 1);
    check_irq("R5 request returns after reti", 1, 4);
    do_clr; step(1);
    chk("R6 gie_clr", int'(gie), 0);
    check_irq("R6 masked after clear", 0, 0);
    int_req = '0;
    do_set;
    int_req[2] = 1; step(2);
    check_irq("R7 internal source 2", 1, 6);
    irq_ack = 1; gie_set = 1; step(1); irq_ack = 0; gie_set = 0;
    chk("R6 ack wins over gie_set", int'(gie), 0);
    int_req = '0;
    do_reti; step(2);
  endtask

  task automatic t_ext_level;
    wcfg(1, 4'b0100);
    ext_pin[0] = 0; step(6);
    check_irq("R8 disabled line ignored", 0, 0);
    wcfg(0, 2'b01); step(2);
    check_irq("R8 R9 low level line 0", 1, 2);
    int_req[0] = 1; step(2);
    check_irq("R2 external beats internal", 1, 2);
    ext_pin[0] = 1; step(6);
    check_irq("R9 level not remembered", 1, 4);
    int_req = '0; step(2);
    check_irq("R9 idle after level release", 0, 0);
    do_clr;
    ext_pin[0] = 0; step(6);
    check_irq("R8 external needs gie", 0, 0);
    ext_pin[0] = 1; step(6);
    do_set; step(2);
    check_irq("R9 released level gone", 0, 0);
  endtask

  task automatic t_edge;
    wcfg(1, 4'b1110);
    wcfg(0, 2'b11);
    step(6);
    ext_pin[0] = 0; step(1); ext_pin[0] = 1; step(6);
    check_irq("R10 falling edge remembered", 1, 2);
    do_ack; do_reti; step(3);
    check_irq("R10 edge forgotten after ack", 0, 0);
    ext_pin[1] = 0; step(6);
    check_irq("R9 falling ignored on rising line", 0, 0);
    ext_pin[1] = 1; step(6);
    check_irq("R9 rising edge line 1", 1, 3);
    do_ack; do_reti; step(3);
    check_irq("R10 rising edge cleared", 0, 0);
    do_clr;
    ext_pin[0] = 0; step(1); ext_pin[0] = 1; step(6);
    check_irq("R10 masked edge not presented", 0, 0);
    do_set; step(2);
    check_irq("R10 edge kept while masked", 1, 2);
    do_ack; do_reti; step(2);
  endtask

  task automatic t_relocate;
    wcfg(2, 16'h0100); base_m = 16'h0100;
    int_req[2] = 1; step(3);
    check_irq("R4 relocated base", 1, 6);
    chk("R4 relocated address value", int'(irq_addr), 16'h0114);
    int_req = '0; step(2);
  endtask

  task automatic t_nest;
    int_req[0] = 1; step(2);
    check_irq("R11 outer request", 1, 4);
    do_ack;
    int_req[0] = 0; int_req[3] = 1; step(2);
    check_irq("R11 blocked before re-enable", 0, 0);
    do_set; step(1);
    check_irq("R11 nested lower priority taken", 1, 7);
    do_ack; int_req = '0;
    do_reti; do_reti; step(2);
  endtask

  task automatic t_rstreq;
    do_clr;
    rst_req = 1; step(1); rst_req = 0; step(1);
    check_irq("R1 reset request while masked", 1, 1);
    do_ack; step(2);
    check_irq("R1 reset request cleared", 0, 0);
  endtask

  initial begin
    t_reset;
    t_internal;
    t_ext_level;
    t_edge;
    t_relocate;
    t_nest;
    t_rstreq;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule